// File: doc/BRIEF.md
# Soft-Start Reference Sequencer

This block generates the digital setpoint that feeds the reference input of a step-down converter's error amplifier. At start-up the setpoint does not jump to full scale. It climbs a staircase of equal steps, and each step lasts a fixed number of switching-clock periods. Because every interval is counted in switching-clock ticks, the start-up time grows or shrinks with the switching frequency. A DAC outside this block turns the code into a voltage.

The block runs on a fast system clock. A single-cycle `sw_tick` pulse marks each switching period. Raising `en` starts a ramp from code 0. When the current-limit logic decides a fault restart is needed, it pulses `fault_rst`. The sequencer then forces the code to zero and keeps it there for one full soft-start interval, counted in ticks. After that it ramps again. With the default parameters the staircase has 64 steps of 32 ticks each. The full soft-start interval is 2048 ticks, and the zero hold after a restart is also 2048 ticks.

Top module: `ssref_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `ref_code`=0, `ss_active`=0 and `ss_done`=0.
- R2: When `en` is low at a clock edge, the next outputs are `ref_code`=0, `ss_active`=0 and `ss_done`=0, whatever `fault_rst` and `sw_tick` are doing.
- R3: The first edge with `en` high after a disabled period starts a ramp immediately, with no hold. The outputs become code 0 with `ss_active`=1, and code 1 appears after exactly 32 further ticks.
- R4: During a ramp, `ref_code` equals floor(n/32), where n is the number of ticks since the ramp began. On any single edge the code either stays the same or rises by exactly one.
- R5: After 2016 ticks of ramp the code reaches 63 (all ones). From that point `ss_done`=1 and `ss_active`=0, and further ticks leave the code at 63.
- R6: `ss_done` stays high until `en` goes low or `fault_rst` is seen. `ss_done` and `ss_active` are never high together.
- R7: When `fault_rst` is high with `en` high, the next outputs are code 0, `ss_active`=1 and `ss_done`=0. The code stays 0 for 2048 ticks of hold. A new ramp then begins, so code 1 first appears after 2048+32 ticks.
- R8: A `fault_rst` that arrives during a hold or during a ramp restarts the 2048-tick hold from zero.
- R9: `en` low takes priority over `fault_rst`: with both applied, the block turns off and does not enter a hold.
- R10: An edge without `sw_tick` never changes `ref_code` while `en` is high and `fault_rst` is low. All timing is counted in ticks only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low forces the off state |
| fault_rst | input | 1 | Fault restart request (hiccup) |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| ref_code | output | STEP_W (6) | Reference step code, saturating at all ones |
| ss_active | output | 1 | High during the zero hold and during the ramp |
| ss_done | output | 1 | High once the code has reached full scale |

## Verification
The assertions check the following on every cycle:
- The code moves by at most one step per edge and never moves on an edge without a tick.
- Disable and restart force the required outputs on the next edge.
- `ss_done` implies full scale, and the two flags are never both high.
- `ss_done` persists while nothing clears it.

The long-window behaviours can only be shown by the bench scenarios: the exact tick counts of 32 per step, 2016 to reach full scale, and 2048 of hold. The same applies to the re-arming of the hold by a second restart, and to the lack of any hold when the block is simply enabled.

// File: rtl/ssref_pkg.sv
package ssref_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    SS_OFF  = 2'd0,  // disabled, reference at zero
    SS_HOLD = 2'd1,  // hiccup wait with the reference at zero
    SS_RAMP = 2'd2,  // staircase climbing
    SS_DONE = 2'd3   // full scale reached
  } ss_state_e;

endpackage

// File: rtl/ssref_span_ctr.sv
// Tick counter shared by the hold and ramp phases.
module ssref_span_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         full
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + {{(W-1){1'b0}}, 1'b1};
    end
  end

  assign full = &cnt;

endmodule

// File: rtl/ssref_ctrl.sv
// Phase control: decides the next phase, the counter action and the next step code.
module ssref_ctrl
  import ssref_pkg::*;
#(
  parameter int STEP_W = 6,
  parameter int CYC_W  = 5,
  localparam int CNT_W = STEP_W + CYC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              restart,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              full,
  output logic              ctr_clr,
  output logic              ctr_inc,
  output ss_state_e         state_nxt,
  output logic [STEP_W-1:0] step_nxt
);

  localparam logic [STEP_W-1:0] STEP_TOP = '1;
  localparam logic [STEP_W-1:0] STEP_PEN = STEP_TOP - {{(STEP_W-1){1'b0}}, 1'b1};
  localparam logic [STEP_W-1:0] STEP_ONE = {{(STEP_W-1){1'b0}}, 1'b1};

  ss_state_e         state_q;
  logic [STEP_W-1:0] cur_step;
  logic              step_wrap;
  logic              at_pen;

  assign cur_step  = cnt[CNT_W-1:CYC_W];
  assign step_wrap = &cnt[CYC_W-1:0];
  assign at_pen    = (cur_step == STEP_PEN);

  always_comb begin
    state_nxt = state_q;
    ctr_clr   = 1'b0;
    ctr_inc   = 1'b0;
    step_nxt  = cur_step;
    if (!en) begin
      state_nxt = SS_OFF;
      ctr_clr   = 1'b1;
      step_nxt  = '0;
    end else if (restart) begin
      state_nxt = SS_HOLD;
      ctr_clr   = 1'b1;
      step_nxt  = '0;
    end else begin
      unique case (state_q)
        SS_OFF: begin
          state_nxt = SS_RAMP;
          ctr_clr   = 1'b1;
          step_nxt  = '0;
        end
        SS_HOLD: begin
          step_nxt = '0;
          if (tick) begin
            if (full) begin
              state_nxt = SS_RAMP;
              ctr_clr   = 1'b1;
            end else begin
              ctr_inc = 1'b1;
            end
          end
        end
        SS_RAMP: begin
          if (tick) begin
            ctr_inc = 1'b1;
            if (step_wrap) begin
              step_nxt = cur_step + STEP_ONE;
              if (at_pen) begin
                state_nxt = SS_DONE;
              end
            end
          end
        end
        SS_DONE: begin
          step_nxt = STEP_TOP;
        end
        default: begin
          state_nxt = SS_OFF;
          ctr_clr   = 1'b1;
          step_nxt  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SS_OFF;
    end else begin
      state_q <= state_nxt;
    end
  end

endmodule

// File: rtl/ssref_outreg.sv
// Registered outputs aligned with the phase register.
module ssref_outreg
  import ssref_pkg::*;
#(
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  ss_state_e         state_nxt,
  input  logic [STEP_W-1:0] step_nxt,
  output logic [STEP_W-1:0] ref_code,
  output logic              ss_active,
  output logic              ss_done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_code  <= '0;
      ss_active <= 1'b0;
      ss_done   <= 1'b0;
    end else begin
      ref_code  <= step_nxt;
      ss_active <= (state_nxt == SS_HOLD) || (state_nxt == SS_RAMP);
      ss_done   <= (state_nxt == SS_DONE);
    end
  end

endmodule

// File: rtl/ssref_seq.sv
// Staircase soft-start reference sequencer, top level.
module ssref_seq
  import ssref_pkg::*;
#(
  parameter int STEP_W = 6,  // 2**STEP_W steps
  parameter int CYC_W  = 5   // 2**CYC_W ticks per step
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fault_rst,
  input  logic              sw_tick,
  output logic [STEP_W-1:0] ref_code,
  output logic              ss_active,
  output logic              ss_done
);

  localparam int CNT_W = STEP_W + CYC_W;

  logic [CNT_W-1:0]  cnt;
  logic              full;
  logic              ctr_clr;
  logic              ctr_inc;
  ss_state_e         state_nxt;
  logic [STEP_W-1:0] step_nxt;

  ssref_span_ctr #(.W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .clr  (ctr_clr),
    .inc  (ctr_inc),
    .cnt  (cnt),
    .full (full)
  );

  ssref_ctrl #(.STEP_W(STEP_W), .CYC_W(CYC_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .restart   (fault_rst),
    .tick      (sw_tick),
    .cnt       (cnt),
    .full      (full),
    .ctr_clr   (ctr_clr),
    .ctr_inc   (ctr_inc),
    .state_nxt (state_nxt),
    .step_nxt  (step_nxt)
  );

  ssref_outreg #(.STEP_W(STEP_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .state_nxt (state_nxt),
    .step_nxt  (step_nxt),
    .ref_code  (ref_code),
    .ss_active (ss_active),
    .ss_done   (ss_done)
  );

endmodule

// File: rtl/ssref_seq_chk.sv
// Port-level properties of the sequencer.
module ssref_seq_chk #(
  parameter int STEP_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              fault_rst,
  input logic              sw_tick,
  input logic [STEP_W-1:0] ref_code,
  input logic              ss_active,
  input logic              ss_done
);

  localparam logic [STEP_W-1:0] ONE = {{(STEP_W-1){1'b0}}, 1'b1};

  p_off_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (ref_code == '0) && !ss_active && !ss_done);

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !fault_rst) |=> (ref_code == $past(ref_code)) || (ref_code == $past(ref_code) + ONE));

  p_done_full_r5: assert property (@(posedge clk) disable iff (rst)
    ss_done |-> (ref_code == '1));

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(ss_done && ss_active));

  p_done_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (ss_done && en && !fault_rst) |=> ss_done);

  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (en && fault_rst) |=> (ref_code == '0) && ss_active && !ss_done);

  p_no_tick_r10: assert property (@(posedge clk) disable iff (rst)
    (en && !fault_rst && !sw_tick) |=> $stable(ref_code));

endmodule

bind ssref_seq ssref_seq_chk #(.STEP_W(STEP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .fault_rst (fault_rst),
  .sw_tick   (sw_tick),
  .ref_code  (ref_code),
  .ss_active (ss_active),
  .ss_done   (ss_done)
);

// File: tb/ssref_seq_bench.sv
module ssref_seq_bench;

  localparam int STEP_W = 6;
  localparam int CYC_W  = 5;
  localparam int NSTEP  = 1 << STEP_W;
  localparam int NCYC   = 1 << CYC_W;
  localparam int SPAN   = NSTEP * NCYC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic fault_rst = 1'b0;
  logic sw_tick = 1'b0;
  logic [STEP_W-1:0] ref_code;
  logic ss_active;
  logic ss_done;

  int checks = 0;
  int failures = 0;

  // expected-behaviour model: 0 off, 1 hold, 2 ramp, 3 done
  int m_st = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  ssref_seq #(.STEP_W(STEP_W), .CYC_W(CYC_W)) u_ssref_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .fault_rst (fault_rst),
    .sw_tick   (sw_tick),
    .ref_code  (ref_code),
    .ss_active (ss_active),
    .ss_done   (ss_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code();
    int s;
    if (m_st < 2) return 0;
    s = m_cnt / NCYC;
    return (s > NSTEP - 1) ? NSTEP - 1 : s;
  endfunction

  task automatic cyc(input logic e, input logic r, input logic t);
    @(negedge clk);
    en = e; fault_rst = r; sw_tick = t;
    @(posedge clk);
    if (!e) begin
      m_st = 0; m_cnt = 0;
    end else if (r) begin
      m_st = 1; m_cnt = 0;
    end else begin
      case (m_st)
        0: begin m_st = 2; m_cnt = 0; end
        1: if (t) begin
             if (m_cnt == SPAN - 1) begin m_st = 2; m_cnt = 0; end
             else m_cnt++;
           end
        2: if (t) begin
             m_cnt++;
             if (m_cnt / NCYC == NSTEP - 1) m_st = 3;
           end
        default: ;
      endcase
    end
    #1;
    chk("R4 code", int'(ref_code), exp_code());
    chk("R7 active", int'(ss_active), (m_st == 1 || m_st == 2) ? 1 : 0);
    chk("R6 done", int'(ss_done), (m_st == 3) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset
    repeat (3) @(posedge clk);
    #1;
    chk("R1 code", int'(ref_code), 0);
    chk("R1 active", int'(ss_active), 0);
    chk("R1 done", int'(ss_done), 0);
    @(negedge clk); rst = 1'b0;

    // R3 enable starts a ramp at once
    cyc(1, 0, 0);
    chk("R3 code", int'(ref_code), 0);
    chk("R3 active", int'(ss_active), 1);
    for (int k = 1; k <= (NSTEP - 1) * NCYC; k++) begin
      cyc(1, 0, 1);
      if (k == NCYC - 1) chk("R3 code before first step", int'(ref_code), 0);
      if (k == NCYC) chk("R3 first step", int'(ref_code), 1);
      if (k == 5 * NCYC + 7) chk("R4 floor", int'(ref_code), 5);
      if (k == (NSTEP - 1) * NCYC - 1) chk("R5 not yet done", int'(ss_done), 0);
    end
    chk("R5 done", int'(ss_done), 1);
    chk("R5 full scale", int'(ref_code), NSTEP - 1);
    chk("R5 active low", int'(ss_active), 0);
    for (int k = 0; k < 40; k++) cyc(1, 0, k % 2 == 0);
    chk("R5 saturated", int'(ref_code), NSTEP - 1);
    chk("R6 done kept", int'(ss_done), 1);

    // R7 restart from done: hold then ramp, ticks every other cycle
    cyc(1, 1, 1);
    chk("R7 code zero", int'(ref_code), 0);
    chk("R7 done cleared", int'(ss_done), 0);
    chk("R7 active", int'(ss_active), 1);
    for (int k = 1; k <= SPAN + NCYC - 1; k++) begin
      cyc(1, 0, 0);
      cyc(1, 0, 1);
    end
    chk("R7 still zero after hold+31", int'(ref_code), 0);
    cyc(1, 0, 1);
    chk("R7 first step after hold", int'(ref_code), 1);

    // R10 idle cycles do not advance
    for (int k = 0; k < 40; k++) cyc(1, 0, 0);
    chk("R10 no tick no move", int'(ref_code), 1);

    // R8 restart mid-ramp, then again mid-hold
    cyc(1, 1, 0);
    chk("R8 mid-ramp restart", int'(ref_code), 0);
    for (int k = 0; k < 1000; k++) cyc(1, 0, 1);
    cyc(1, 1, 1);
    for (int k = 1; k <= SPAN + NCYC - 1; k++) cyc(1, 0, 1);
    chk("R8 hold re-armed", int'(ref_code), 0);
    cyc(1, 0, 1);
    chk("R8 step after re-armed hold", int'(ref_code), 1);

    // R9 disable wins over restart
    cyc(0, 1, 1);
    chk("R9 code", int'(ref_code), 0);
    chk("R9 active", int'(ss_active), 0);
    for (int k = 0; k < 5; k++) cyc(0, k % 2 == 1, 1);
    chk("R2 off active", int'(ss_active), 0);
    cyc(1, 0, 1);
    chk("R3 re-enable active", int'(ss_active), 1);
    for (int k = 1; k <= NCYC; k++) cyc(1, 0, 1);
    chk("R3 re-enable no hold", int'(ref_code), 1);

    // R2 disable from done
    for (int k = 0; k < SPAN; k++) cyc(1, 0, 1);
    chk("R5 done again", int'(ss_done), 1);
    cyc(0, 0, 1);
    chk("R2 done cleared", int'(ss_done), 0);
    chk("R2 code", int'(ref_code), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule